// File: doc/BRIEF.md
# Open-Bank Recency Tracker

This block sits in front of a DRAM command path and remembers which banks currently hold an open row. Up to four banks are tracked, each with its open row, in a list ordered from most to least recently used. A requester presents a bank, a row, a read-not-write bit and a conflict hint. The block checks the request against its own list. A request that finds its bank already open on the same row goes straight out as a column command, and the requester is never stalled. This holds whatever the hint says, so a hint that reports a conflict where none exists costs nothing.

Any other request stalls the requester. If the bank is absent and all four entries are in use, the least recently used bank is precharged. If the bank is open on a different row, that same bank is precharged. If free entries remain, no precharge is needed. The requested bank and row are then activated, and the column command follows. A fixed, parameterised number of idle cycles separates precharge from activate and activate from the column command. Every accepted request moves its bank to the front of the list.

Top module: `lru_bank_tracker`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_op` is NOP, and no bank is tracked as open, so the first request to any bank produces no precharge.
- R2: `cmd_op` carries exactly one command per cycle, encoded as 0 = NOP, 1 = precharge, 2 = activate, 3 = read, 4 = write. No other value appears.
- R3: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. Requests presented while `req_ready` is 0 change neither the command stream nor the tracked banks.
- R4: A request whose bank is tracked as open with the same row keeps `req_ready` at 1. In the next cycle it issues read (3) or write (4) with the requested bank and row, and no precharge or activate.
- R5: On such a hit, the matched entry becomes most recent. Entries that were more recent than it each move one place older, and older entries keep their positions.
- R6: A request whose bank is not tracked while four banks are tracked drops `req_ready` in the next cycle. In that same cycle it issues a precharge carrying the bank and row of the least recently used entry.
- R7: After a precharge, exactly GAP NOP cycles pass before an activate of the requested bank and row. Exactly GAP NOP cycles then pass before the read or write of that bank and row.
- R8: `req_ready` is 0 during the cycle of the final read or write of a stalled request, and returns to 1 in the following cycle.
- R9: After a real conflict, the new bank is the most recent entry and the evicted bank is no longer tracked. A later request to the evicted bank is treated as a miss.
- R10: While fewer than four banks are tracked, a request to an untracked bank stalls the requester and issues an activate in the next cycle with no precharge. The new bank becomes most recent.
- R11: A request whose bank is tracked with a different row precharges that bank with its old row, then activates the new row. The entry moves to the most recent position with the new row, and no other bank is evicted.
- R12: The conflict hint `req_conflict` has no effect on the command sequence, the ready signal or the tracked state.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_bank | input | BANK_W | Requested bank |
| req_row | input | ROW_W | Requested row |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_conflict | input | 1 | Requester's conflict hint (advisory only) |
| req_ready | output | 1 | Block can take a request this cycle |
| cmd_op | output | 3 | Issued command code |
| cmd_bank | output | BANK_W | Bank of the issued command |
| cmd_row | output | ROW_W | Row of the issued command |

## Verification
The list is first filled from empty, which separates the activate-only path from the eviction path. Hits are then aimed at every position with the hint both set and clear. This shows that the hint is ignored, and the order of later evictions shows whether the shift kept the entries below the hit in place. Misses on all untracked banks, with garbage requests held on the interface while stalled, separate eviction of the oldest entry from any other choice, and show that stalled requests are discarded. Same-bank row changes at each position, followed by a long pseudo-random stream over eight banks and three rows checked against an arithmetic recency model, cover mixed orderings.

// File: rtl/lru_bank_tracker.sv
module lru_bank_tracker #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int DEPTH  = 4,
  parameter int GAP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              req_rd,
  input  logic              req_conflict,
  output logic              req_ready,
  output logic [2:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = (GAP > 0) ? $clog2(GAP + 1) : 1;
  localparam logic [2:0] OP_NOP = 3'd0, OP_PRE = 3'd1, OP_ACT = 3'd2,
                         OP_RD  = 3'd3, OP_WR  = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE_GAP, ST_ACT_GAP, ST_LAST} state_t;

  state_t             state;
  logic [CNT_W-1:0]   gap_cnt;
  logic [BANK_W-1:0]  pnd_b;
  logic [ROW_W-1:0]   pnd_r;
  logic               pnd_rd;

  logic               ent_v [DEPTH];
  logic [BANK_W-1:0]  ent_b [DEPTH];
  logic [ROW_W-1:0]   ent_r [DEPTH];

  logic               accept, any_match, row_hit, need_pre, full, hint_unused;
  logic [IDX_W-1:0]   match_idx, first_free, tgt;
  logic [BANK_W-1:0]  victim_b;
  logic [ROW_W-1:0]   victim_r;

  assign req_ready   = (state == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign full        = ent_v[DEPTH-1];
  assign hint_unused = req_conflict;

  always_comb begin
    any_match  = 1'b0;
    match_idx  = '0;
    first_free = IDX_W'(DEPTH - 1);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (ent_v[i] && ent_b[i] == req_bank) begin
        any_match = 1'b1;
        match_idx = IDX_W'(i);
      end
      if (!ent_v[i]) first_free = IDX_W'(i);
    end
  end

  assign row_hit  = any_match && (ent_r[match_idx] == req_row);
  assign need_pre = any_match ? !row_hit : full;
  assign tgt      = any_match ? match_idx : (full ? IDX_W'(DEPTH - 1) : first_free);
  assign victim_b = ent_b[tgt];
  assign victim_r = ent_r[tgt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_v[i] <= 1'b0;
        ent_b[i] <= '0;
        ent_r[i] <= '0;
      end
    end else if (accept) begin
      for (int i = 1; i < DEPTH; i++) begin
        if (IDX_W'(i) <= tgt) begin
          ent_v[i] <= ent_v[i-1];
          ent_b[i] <= ent_b[i-1];
          ent_r[i] <= ent_r[i-1];
        end
      end
      ent_v[0] <= 1'b1;
      ent_b[0] <= req_bank;
      ent_r[0] <= req_row;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      gap_cnt  <= '0;
      pnd_b    <= '0;
      pnd_r    <= '0;
      pnd_rd   <= 1'b0;
      cmd_op   <= OP_NOP;
      cmd_bank <= '0;
      cmd_row  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cmd_op <= OP_NOP;
          if (accept) begin
            if (row_hit) begin
              cmd_op   <= req_rd ? OP_RD : OP_WR;
              cmd_bank <= req_bank;
              cmd_row  <= req_row;
            end else begin
              pnd_b   <= req_bank;
              pnd_r   <= req_row;
              pnd_rd  <= req_rd;
              gap_cnt <= CNT_W'(GAP);
              if (need_pre) begin
                cmd_op   <= OP_PRE;
                cmd_bank <= victim_b;
                cmd_row  <= victim_r;
                state    <= ST_PRE_GAP;
              end else begin
                cmd_op   <= OP_ACT;
                cmd_bank <= req_bank;
                cmd_row  <= req_row;
                state    <= ST_ACT_GAP;
              end
            end
          end
        end
        ST_PRE_GAP: begin
          if (gap_cnt == '0) begin
            cmd_op   <= OP_ACT;
            cmd_bank <= pnd_b;
            cmd_row  <= pnd_r;
            gap_cnt  <= CNT_W'(GAP);
            state    <= ST_ACT_GAP;
          end else begin
            cmd_op  <= OP_NOP;
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        ST_ACT_GAP: begin
          if (gap_cnt == '0) begin
            cmd_op   <= pnd_rd ? OP_RD : OP_WR;
            cmd_bank <= pnd_b;
            cmd_row  <= pnd_r;
            state    <= ST_LAST;
          end else begin
            cmd_op  <= OP_NOP;
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        default: begin
          cmd_op <= OP_NOP;
          state  <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/lru_bank_tracker_chk.sv
module lru_bank_tracker_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic              req_rd,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic              row_hit,
  input logic              need_pre,
  input logic [BANK_W-1:0] victim_b,
  input logic [ROW_W-1:0]  victim_r
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op <= 3'd4); // R2
  AST_HIT_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && row_hit |=> req_ready && cmd_op == ($past(req_rd) ? 3'd3 : 3'd4)
      && cmd_bank == $past(req_bank) && cmd_row == $past(req_row)); // R4
  AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !row_hit |=> !req_ready); // R6
  AST_EVICT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !row_hit && need_pre |=> cmd_op == 3'd1
      && cmd_bank == $past(victim_b) && cmd_row == $past(victim_r)); // R6
  AST_FILL_NO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !row_hit && !need_pre |=> cmd_op == 3'd2 && cmd_bank == $past(req_bank)); // R10
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && (cmd_op == 3'd3 || cmd_op == 3'd4) |=> req_ready && cmd_op == 3'd0); // R8
endmodule

bind lru_bank_tracker lru_bank_tracker_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bank(req_bank), .req_row(req_row), .req_rd(req_rd), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_row(cmd_row), .row_hit(row_hit), .need_pre(need_pre),
  .victim_b(victim_b), .victim_r(victim_r)
);

// File: tb/test_lru_bank_tracker.sv
`timescale 1ns/1ps
module test_lru_bank_tracker;
  localparam int BW = 3, RW = 14, GP = 2;

  logic          clk = 0, rst_n = 0;
  logic          req_valid = 0, req_rd = 0, req_conflict = 0;
  logic [BW-1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic          req_ready;
  logic [2:0]    cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;

  int nchk = 0, nfail = 0, bad_ops = 0;
  int mb[4], mr[4];
  bit mv[4];
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  lru_bank_tracker #(.BANK_W(BW), .ROW_W(RW), .DEPTH(4), .GAP(GP)) i_lru_bank_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_rd(req_rd), .req_conflict(req_conflict),
    .req_ready(req_ready), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row));

  always @(negedge clk) if (rst_n && cmd_op > 3'd4) bad_ops++;

  task automatic chk(input bit ok, input string tg, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  task automatic chk_cmd(input int op, input int b, input int r, input bit rdy, input string tg);
    chk(int'(cmd_op) == op, {tg, " op"}, int'(cmd_op), op);
    if (op != 0) begin
      chk(int'(cmd_bank) == b, {tg, " bank"}, int'(cmd_bank), b);
      chk(int'(cmd_row) == r, {tg, " row"}, int'(cmd_row), r);
    end
    chk(req_ready == rdy, {tg, " ready"}, int'(req_ready), int'(rdy));
  endtask

  function automatic int rnd(input int n);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % n);
  endfunction

  task automatic do_req(input int b, input int r, input bit rd, input bit cf, input bit poke);
    int m = -1, nv = 0, tgt, vb, vr, col;
    bit hit, pre;
    while (!req_ready) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      if (mv[i]) nv++;
      if (mv[i] && mb[i] == b) m = i;
    end
    hit = (m >= 0) && (mr[m] == r);
    pre = (m >= 0) ? !hit : (nv == 4);
    tgt = (m >= 0) ? m : ((nv == 4) ? 3 : nv);
    vb = mb[tgt]; vr = mr[tgt];
    col = rd ? 3 : 4;
    req_valid = 1; req_bank = BW'(b); req_row = RW'(r); req_rd = rd; req_conflict = cf;
    @(negedge clk);
    if (poke) begin
      req_bank = BW'(b + 3); req_row = RW'(r + 1); req_rd = !rd; req_conflict = !cf;
    end else req_valid = 0;
    if (hit) begin
      req_valid = 0;
      chk_cmd(col, b, r, 1, cf ? "R4 R12 hit" : "R4 R5 hit");
    end else begin
      if (pre) begin
        chk_cmd(1, vb, vr, 0, (m >= 0) ? "R11 precharge" : "R6 R5 R9 precharge");
        for (int k = 0; k < GP; k++) begin @(negedge clk); chk_cmd(0, 0, 0, 0, "R7 gap1"); end
        @(negedge clk);
        chk_cmd(2, b, r, 0, "R7 activate");
      end else
        chk_cmd(2, b, r, 0, "R10 R1 activate only");
      for (int k = 0; k < GP; k++) begin @(negedge clk); chk_cmd(0, 0, 0, 0, "R7 gap2"); end
      @(negedge clk);
      chk_cmd(col, b, r, 0, "R7 R8 column");
      @(negedge clk);
      req_valid = 0;
      chk_cmd(0, 0, 0, 1, poke ? "R8 R3 ready back" : "R8 ready back");
    end
    for (int i = tgt; i > 0; i--) begin mv[i] = mv[i-1]; mb[i] = mb[i-1]; mr[i] = mr[i-1]; end
    mv[0] = 1; mb[0] = b; mr[0] = r;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mb[i] = 0; mr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(cmd_op == 3'd0, "R1 NOP after reset", int'(cmd_op), 0);
    for (int b = 0; b < 4; b++) do_req(b, b, b[0], 1, 0);
    for (int p = 0; p < 4; p++)
      for (int cf = 0; cf < 2; cf++) do_req(mb[p], mr[p], cf[0], cf[0], 0);
    for (int b = 4; b < 8; b++) do_req(b, b % 3, b[0], 1, 1);
    for (int b = 0; b < 4; b++) do_req(b, b, 1, 0, 0);
    for (int p = 3; p >= 0; p--) do_req(mb[p], mr[p] + 5, 0, 1, 0);
    for (int n = 0; n < 600; n++)
      do_req(rnd(8), rnd(3), rnd(2) == 1, rnd(2) == 1, rnd(4) == 0);
    @(negedge clk);
    chk(bad_ops == 0, "R2 legal command codes", bad_ops, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule